// File: doc/BRIEF.md
# Carry-Less Multiplier

This block multiplies two 64-bit operands as polynomials over GF(2). Partial products are combined with XOR, so no carries propagate, and the full product is 128 bits wide. A 2-bit view select chooses which 64-bit slice of that product comes back: the lower half, the upper half, or a "reversed" slice taken one bit below the upper half. The reversed slice is the form that bit-reflected CRC and GCM-style reductions use.

The unit is iterative. When idle, a start pulse captures both operands and the view select. The unit then consumes `STEP` bits of the second operand per clock. For each set bit, it folds the first operand, shifted to that bit's weight, into a 128-bit accumulator. Once the last bit is consumed, the chosen slice is registered on the result port and a one-cycle done pulse is raised. The result then stays put until a later operation completes. Start pulses that arrive while an operation is running are dropped.

Top module: `clmul_unit`

## Requirements
- R1: After reset, `done_o` is 0 and `result_o` is all zeros.
- R2: With view select 0, `result_o` is bits 63..0 of the carry-less product of `opa_i` and `opb_i`.
- R3: With view select 1, `result_o` is bits 127..64 of the product. This equals the view-2 value shifted right by one bit with a zero brought in at bit 63.
- R4: With view select 2, `result_o` is bits 126..63 of the product.
- R5: View select 3 returns the same value as view select 0.
- R6: Both operands are used at their full 64-bit width with no sign or zero extension. An operand with bit 63 set produces the plain polynomial product.
- R7: `done_o` is high for exactly one cycle. It rises on the 64th rising edge after the edge that accepted `start_i`, when `STEP` is 1. Operands and view select are captured at that accepting edge.
- R8: A `start_i` pulse while an operation is in progress is ignored. The running operation finishes on its original schedule, with its original operands and view.
- R9: `result_o` changes only on the edge that raises `done_o`. Otherwise it holds its value, whatever the inputs do.
- R10: A second operand of 1 in view 0 returns the first operand unchanged. A second operand of 0 returns zero in every view.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin an operation; taken only when idle |
| mode_i | input | 2 | View select: 0 low, 1 high, 2 reversed, 3 low |
| opa_i | input | 64 | Multiplicand polynomial |
| opb_i | input | 64 | Multiplier polynomial, scanned from bit 0 upward |
| done_o | output | 1 | One-cycle pulse when `result_o` is updated |
| result_o | output | 64 | Selected slice of the product |

## Verification
With the default one bit per cycle, every result is due on the 64th rising edge after the edge that samples `start_i`. It is visible from the falling edge that follows. The bench raises start half a cycle before the accepting edge and counts falling edges from there. It requires `done_o` to be low on the first 63 of them and high on the 64th, and it compares the result on that same falling edge. The hold check samples `result_o` for several falling edges after done while the operand inputs change. The ignored-start check inserts a second start ten cycles into an operation and still expects completion on the 64th count, with the first operation's value.

// File: rtl/clmul_pkg.sv
package clmul_pkg;

   // Result view select. Encoding 3 aliases the low half.
   typedef enum logic [1:0] {
      VIEW_LO     = 2'd0,
      VIEW_HI     = 2'd1,
      VIEW_REV    = 2'd2,
      VIEW_LO_ALT = 2'd3
   } view_e;

endpackage

// File: rtl/clmul_ctrl.sv
module clmul_ctrl #(
   parameter int XLEN = 64,
   parameter int STEP = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   output logic accept_o,
   output logic step_o,
   output logic last_o
);
   localparam int CYCLES = XLEN / STEP;
   localparam int CW     = (CYCLES > 1) ? $clog2(CYCLES) : 1;

   logic          busy_q;
   logic [CW-1:0] cnt_q;

   assign accept_o = start_i && !busy_q;
   assign step_o   = busy_q;
   assign last_o   = busy_q && (cnt_q == CW'(CYCLES - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         cnt_q  <= '0;
      end else if (accept_o) begin
         busy_q <= 1'b1;
         cnt_q  <= '0;
      end else if (busy_q) begin
         if (last_o) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end
endmodule

// File: rtl/clmul_accum.sv
module clmul_accum #(
   parameter int XLEN = 64,
   parameter int STEP = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic              step_i,
   input  logic [XLEN-1:0]   opa_i,
   input  logic [XLEN-1:0]   opb_i,
   output logic [2*XLEN-1:0] prod_next_o
);
   localparam int PW = 2 * XLEN;

   logic [PW-1:0]   mcand_q;
   logic [XLEN-1:0] mplier_q;
   logic [PW-1:0]   acc_q;
   logic [PW-1:0]   chain [STEP+1];

   assign chain[0] = acc_q;

   // One XOR stage per multiplier bit consumed in a cycle.
   for (genvar j = 0; j < STEP; j++) begin : g_pp
      assign chain[j+1] = chain[j] ^ (mplier_q[j] ? (mcand_q << j) : '0);
   end

   assign prod_next_o = chain[STEP];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mcand_q  <= '0;
         mplier_q <= '0;
         acc_q    <= '0;
      end else if (load_i) begin
         mcand_q  <= {{XLEN{1'b0}}, opa_i};
         mplier_q <= opb_i;
         acc_q    <= '0;
      end else if (step_i) begin
         mcand_q  <= mcand_q << STEP;
         mplier_q <= mplier_q >> STEP;
         acc_q    <= prod_next_o;
      end
   end
endmodule

// File: rtl/clmul_view.sv
module clmul_view
   import clmul_pkg::*;
#(
   parameter int XLEN = 64
) (
   input  logic [2*XLEN-1:0] prod_i,
   input  view_e             view_i,
   output logic [XLEN-1:0]   slice_o
);
   logic [XLEN-1:0] rev_w;

   assign rev_w = prod_i[2*XLEN-2 : XLEN-1];

   always_comb begin
      unique case (view_i)
         VIEW_HI:  slice_o = rev_w >> 1;
         VIEW_REV: slice_o = rev_w;
         default:  slice_o = prod_i[XLEN-1:0];
      endcase
   end
endmodule

// File: rtl/clmul_unit.sv
module clmul_unit
   import clmul_pkg::*;
#(
   parameter int XLEN = 64,
   parameter int STEP = 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start_i,
   input  logic [1:0]      mode_i,
   input  logic [XLEN-1:0] opa_i,
   input  logic [XLEN-1:0] opb_i,
   output logic            done_o,
   output logic [XLEN-1:0] result_o
);
   if (XLEN < 8 || (XLEN % STEP) != 0 || STEP < 1) begin : g_bad_cfg
      $error("clmul_unit: XLEN must be >= 8 and a multiple of STEP");
   end

   logic              accept_w, step_w, last_w;
   logic [2*XLEN-1:0] prod_next_w;
   logic [XLEN-1:0]   slice_w;
   view_e             view_q;
   logic              done_q;
   logic [XLEN-1:0]   result_q;

   clmul_ctrl #(.XLEN(XLEN), .STEP(STEP)) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .start_i  (start_i),
      .accept_o (accept_w),
      .step_o   (step_w),
      .last_o   (last_w)
   );

   clmul_accum #(.XLEN(XLEN), .STEP(STEP)) u_accum (
      .clk         (clk),
      .rst_n       (rst_n),
      .load_i      (accept_w),
      .step_i      (step_w),
      .opa_i       (opa_i),
      .opb_i       (opb_i),
      .prod_next_o (prod_next_w)
   );

   clmul_view #(.XLEN(XLEN)) u_view (
      .prod_i  (prod_next_w),
      .view_i  (view_q),
      .slice_o (slice_w)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         view_q   <= VIEW_LO;
         done_q   <= 1'b0;
         result_q <= '0;
      end else begin
         if (accept_w) view_q <= view_e'(mode_i);
         done_q <= last_w;
         if (last_w) result_q <= slice_w;
      end
   end

   assign done_o   = done_q;
   assign result_o = result_q;
endmodule

// File: rtl/clmul_unit_chk.sv
module clmul_unit_chk #(
   parameter int XLEN = 64,
   parameter int STEP = 1
) (
   input logic            clk,
   input logic            rst_n,
   input logic            start_i,
   input logic [1:0]      mode_i,
   input logic [XLEN-1:0] opa_i,
   input logic [XLEN-1:0] opb_i,
   input logic            done_o,
   input logic [XLEN-1:0] result_o
);
   localparam int CYCLES = XLEN / STEP;

   logic            run_m;
   int unsigned     age_m;
   logic [1:0]      cap_mode;
   logic [XLEN-1:0] cap_a, cap_b;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_m    <= 1'b0;
         age_m    <= 0;
         cap_mode <= '0;
         cap_a    <= '0;
         cap_b    <= '0;
      end else if (start_i && !run_m) begin
         run_m    <= 1'b1;
         age_m    <= 0;
         cap_mode <= mode_i;
         cap_a    <= opa_i;
         cap_b    <= opb_i;
      end else if (run_m) begin
         if (age_m == CYCLES - 1) run_m <= 1'b0;
         else age_m <= age_m + 1;
      end
   end

   // R7
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   // R7 R8
   done_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> ($past(run_m) && $past(age_m) == CYCLES - 1));

   // R9
   hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !done_o |-> $stable(result_o));

   // R10
   identity_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && cap_mode == 2'd0 && cap_b == XLEN'(1)) |-> result_o == cap_a);

   // R10
   zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && cap_b == '0) |-> result_o == '0);
endmodule

bind clmul_unit clmul_unit_chk #(.XLEN(XLEN), .STEP(STEP)) u_chk (.*);

// File: tb/clmul_unit_test.sv
module clmul_unit_test;
   localparam int XLEN = 64;
   localparam int LAT  = 64;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            start_i = 1'b0;
   logic [1:0]      mode_i = '0;
   logic [XLEN-1:0] opa_i = '0, opb_i = '0;
   logic            done_o;
   logic [XLEN-1:0] result_o;

   int checks = 0;
   int fails  = 0;

   always #10 clk = ~clk;

   clmul_unit #(.XLEN(XLEN), .STEP(1)) uut (.*);

   localparam logic [127:0] VEC [8] = '{
      {64'h0000_0000_0000_0003, 64'h0000_0000_0000_0003},
      {64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF},
      {64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000},
      {64'h0123_4567_89AB_CDEF, 64'hFEDC_BA98_7654_3210},
      {64'hDEAD_BEEF_CAFE_F00D, 64'h1357_9BDF_2468_ACE0},
      {64'h8000_0000_0000_0001, 64'h0000_0000_0000_0005},
      {64'h0000_0000_0000_0001, 64'hA5A5_5A5A_F0F0_0F0F},
      {64'h7FFF_0000_FFFF_8000, 64'h8000_0001_0000_0003}
   };

   function automatic logic [127:0] ref_prod(logic [63:0] a, logic [63:0] b);
      logic [127:0] p = '0;
      for (int i = 0; i < 64; i++)
         if (b[i]) p = p ^ ({64'd0, a} << i);
      return p;
   endfunction

   function automatic logic [63:0] ref_view(logic [127:0] p, logic [1:0] m);
      case (m)
         2'd1:    return p[127:64];
         2'd2:    return p[126:63];
         default: return p[63:0];
      endcase
   endfunction

   task automatic chk(input bit ok, input string req, input logic [63:0] act,
                      input logic [63:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   // Runs one operation; optionally injects a start at count 10 with other data.
   task automatic run_op(input logic [63:0] a, input logic [63:0] b,
                         input logic [1:0] m, input bit inject,
                         output logic [63:0] res, output int lat, output bit early);
      early = 0;
      @(negedge clk);
      start_i = 1'b1; opa_i = a; opb_i = b; mode_i = m;
      @(posedge clk);
      @(negedge clk);
      start_i = 1'b0;
      opa_i = ~a; opb_i = ~b; mode_i = ~m;
      lat = 0;
      while (!done_o && lat < 100) begin
         if (inject && lat == 10) start_i = 1'b1;
         if (inject && lat == 11) start_i = 1'b0;
         @(negedge clk);
         lat++;
         if (lat < LAT && done_o) early = 1;
      end
      res = result_o;
   endtask

   task automatic summary();
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog act=%h exp=%h", 64'd0, 64'd1);
      summary();
      $finish;
   end

   initial begin
      logic [63:0] res, prev;
      int lat;
      bit early;
      string tag;

      repeat (3) @(negedge clk);
      // R1: reset state
      chk(done_o == 1'b0, "R1 done", {63'd0, done_o}, 64'd0);
      chk(result_o == '0, "R1 result", result_o, 64'd0);
      rst_n = 1'b1;

      // R2 R3 R4 R5 R6: table walk over every view
      for (int v = 0; v < 8; v++) begin
         for (int m = 0; m < 4; m++) begin
            logic [127:0] p;
            p = ref_prod(VEC[v][127:64], VEC[v][63:0]);
            run_op(VEC[v][127:64], VEC[v][63:0], 2'(m), 1'b0, res, lat, early);
            tag = (m == 0) ? "R2 low" : (m == 1) ? "R3 high" :
                  (m == 2) ? "R4 reversed" : "R5 alias";
            if (VEC[v][127] || VEC[v][63]) tag = {tag, " R6 msb"};
            chk(res == ref_view(p, 2'(m)), tag, res, ref_view(p, 2'(m)));
            // R7: exact latency
            chk(lat == LAT && !early, "R7 latency", 64'(lat), 64'(LAT));
         end
      end

      // R3: high equals reversed >> 1
      begin
         logic [63:0] hi, rv;
         run_op(64'hF00F_1234_5678_9ABC, 64'hC3C3_0000_1111_FFFF, 2'd1, 1'b0, hi, lat, early);
         run_op(64'hF00F_1234_5678_9ABC, 64'hC3C3_0000_1111_FFFF, 2'd2, 1'b0, rv, lat, early);
         chk(hi == (rv >> 1), "R3 hi_vs_rev", hi, rv >> 1);
      end

      // R10: identity and zero
      run_op(64'h9876_5432_10FE_DCBA, 64'd1, 2'd0, 1'b0, res, lat, early);
      chk(res == 64'h9876_5432_10FE_DCBA, "R10 identity", res, 64'h9876_5432_10FE_DCBA);
      for (int m = 0; m < 4; m++) begin
         run_op(64'hFFFF_FFFF_FFFF_FFFF, 64'd0, 2'(m), 1'b0, res, lat, early);
         chk(res == '0, "R10 zero", res, 64'd0);
      end

      // R8: start while busy ignored
      run_op(64'h0000_0000_0000_00FF, 64'h0000_0000_0000_0101, 2'd0, 1'b1, res, lat, early);
      chk(res == ref_view(ref_prod(64'hFF, 64'h101), 2'd0), "R8 result", res,
          ref_view(ref_prod(64'hFF, 64'h101), 2'd0));
      chk(lat == LAT && !early, "R8 latency", 64'(lat), 64'(LAT));
      @(negedge clk);
      chk(done_o == 1'b0, "R7 pulse", {63'd0, done_o}, 64'd0);

      // R9: hold after done while inputs wander
      prev = result_o;
      for (int k = 0; k < 6; k++) begin
         opa_i = 64'(k * 7 + 3); opb_i = 64'(k + 11); mode_i = 2'(k);
         @(negedge clk);
         chk(result_o == prev && !done_o, "R9 hold", result_o, prev);
      end

      summary();
      $finish;
   end
endmodule